// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Pipeline

This block is a single-port synchronous memory whose write data arrives a fixed two clock edges after the write command. That is the same distance as the read data. A bus master can therefore issue reads and writes in any order on consecutive cycles, and the shared data bus never needs an idle turnaround cycle between them. The command is sampled on every enabled clock edge. It is made up of three chip selects, a load/advance control, a read/write flag, four active-low lane write masks and an address. The data bus is split into an input, a registered output and an output-drive flag.

A load cycle starts a new operation at the given address. An advance cycle continues the previous read or write at the next address of a four-beat burst, in either interleaved or linear order. A hold input freezes the whole block for a cycle. The write address and lane masks wait in a two-stage command pipeline until their data is on the bus. A read that finds an older write still pending for its address returns the new data.

Top module: `zt_sram_pipe`

## Requirements
- R1: A load read issued at edge T loads its word into `dq_o` at edge T+1, and `dq_oe` is high from then until edge T+2, which is where the master samples it. This holds when `out_en_n_i` is low.
- R2: The write data for a load write issued at edge T is taken from `dq_i` at edge T+2.
- R3: At a load cycle (`adv_i` = 0) with all selects active, `rd_nwr_i` = 1 starts a read and `rd_nwr_i` = 0 starts a write. At an advance cycle (`adv_i` = 1), the address, the selects and `rd_nwr_i` have no effect.
- R4: A load cycle with `sel_a_n_i` = 1, `sel_b_i` = 0 or `sel_c_n_i` = 1 is a deselect. It performs no access, and operations already in the pipeline still complete.
- R5: `lane_wr_n_i[k]` = 0 writes bits [8k+7:8k]. The other bytes keep their old value. A write with all four masks high changes no memory.
- R6: With `out_en_n_i` = 1 a read still runs, but `dq_oe` stays low.
- R7: With `hold_i` = 1 at an edge, no pipeline stage, burst state, memory word or output changes. A read that is being driven keeps driving the same data.
- R8: During the cycle before a write's data edge, `dq_oe` is low whatever the level of `out_en_n_i`.
- R9: An advance cycle after a deselect (or after reset) performs no access. An advance cycle after a read or write continues that read or write.
- R10: The n-th advance after a load at address A accesses A with its two low bits replaced. In interleaved mode (`burst_lin_i` = 0) they become A[1:0] XOR n. In linear mode they become (A[1:0] + n) mod 4. The upper bits are unchanged, and the sequence wraps after four beats.
- R11: Any mix of reads and writes on consecutive cycles lands each access in its own slot, with no idle cycle needed.
- R12: A read of an address whose write is still pending returns the newly written lanes, merged with the old value of the unwritten lanes.
- R13: Reset clears every pending operation and the burst state, and leaves `dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Freeze the block for this edge |
| sel_a_n_i | input | 1 | Select, active low |
| sel_b_i | input | 1 | Select, active high |
| sel_c_n_i | input | 1 | Select, active low |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new command |
| rd_nwr_i | input | 1 | 1 = read, 0 = write (at a load) |
| lane_wr_n_i | input | LANES | Per-byte write masks, active low |
| addr_i | input | ADDR_W | Word address |
| burst_lin_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n_i | input | 1 | Output enable, active low |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | Drive enable for `dq_o` |

## Verification
A command stuck in the wrong pipeline stage shows up at the ports as a drive window that is one edge early or late, or as read data taken from the wrong word. Both appear within two or three edges of the command. A bypass fault, or a lane write that goes astray, stays hidden in the memory until the affected word is read. For that reason every write is followed by many reads, both immediately and at random later times. A wrong burst counter gives read data from a neighbouring word on the first advance beat.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } zt_op_e;

  // Low address bits of a burst beat: add in linear mode, xor otherwise.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       lin);
    return lin ? (start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic              sel_a_n_i,
  input  logic              sel_b_i,
  input  logic              sel_c_n_i,
  input  logic              adv_i,
  input  logic              rd_nwr_i,
  input  logic              burst_lin_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output zt_op_e            cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_lanes,
  output logic              last_idle
);

  localparam int HI_W = ADDR_W - 2;

  zt_op_e            last_q, last_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        step_q, step_d, step_nx;
  logic              sel_ok;

  always_comb begin
    sel_ok   = !sel_a_n_i && sel_b_i && !sel_c_n_i;
    step_nx  = step_q + 2'd1;
    last_d   = last_q;
    base_d   = base_q;
    step_d   = step_q;
    cmd_op   = OP_IDLE;
    cmd_addr = base_q;
    if (!adv_i) begin
      base_d   = addr_i;
      step_d   = 2'd0;
      cmd_addr = addr_i;
      if (sel_ok) cmd_op = rd_nwr_i ? OP_RD : OP_WR;
      last_d   = cmd_op;
    end else if (last_q != OP_IDLE) begin
      step_d   = step_nx;
      cmd_op   = last_q;
      cmd_addr = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[1:0], step_nx, burst_lin_i)};
    end
    cmd_lanes = (cmd_op == OP_WR) ? ~lane_wr_n_i : '0;
  end

  assign last_idle = (last_q == OP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= OP_IDLE;
      base_q <= '0;
      step_q <= 2'd0;
    end else if (adv_en) begin
      last_q <= last_d;
      base_q <= base_d;
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  zt_op_e            cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_lanes,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic              head_busy
);

  localparam int RD_TAP = STAGES - 2;
  localparam int WR_TAP = STAGES - 1;

  zt_op_e            st_op    [STAGES];
  logic [ADDR_W-1:0] st_addr  [STAGES];
  logic [LANES-1:0]  st_lanes [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st_op[i] <= OP_IDLE;
    end else if (adv_en) begin
      st_op[0]    <= cmd_op;
      st_addr[0]  <= cmd_addr;
      st_lanes[0] <= cmd_lanes;
      for (int i = 1; i < STAGES; i++) begin
        st_op[i]    <= st_op[i-1];
        st_addr[i]  <= st_addr[i-1];
        st_lanes[i] <= st_lanes[i-1];
      end
    end
  end

  assign rd_valid  = (st_op[RD_TAP] == OP_RD);
  assign rd_addr   = st_addr[RD_TAP];
  assign wr_valid  = (st_op[WR_TAP] == OP_WR);
  assign wr_addr   = st_addr[WR_TAP];
  assign wr_lanes  = st_lanes[WR_TAP];
  assign head_busy = (st_op[0] != OP_IDLE);

endmodule

// File: rtl/zt_data_path.sv
module zt_data_path #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv_en,
  input  logic                    rd_valid,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_valid,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] dq_i,
  input  logic                    out_en_n_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_rd, fwd;
  logic [DW-1:0] dq_q;
  logic          drive_q;
  logic          hit;

  assign mem_rd = mem[rd_addr];
  assign hit    = wr_valid && (wr_addr == rd_addr);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign fwd[k*LANE_W +: LANE_W] = (hit && wr_lanes[k]) ? dq_i[k*LANE_W +: LANE_W]
                                                            : mem_rd[k*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (adv_en && wr_valid) begin
      for (int k = 0; k < LANES; k++) begin
        if (wr_lanes[k]) mem[wr_addr][k*LANE_W +: LANE_W] <= dq_i[k*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      dq_q    <= '0;
    end else if (adv_en) begin
      drive_q <= rd_valid;
      if (rd_valid) dq_q <= fwd;
    end
  end

  assign dq_o  = dq_q;
  assign dq_oe = drive_q && !out_en_n_i;

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int PIPE_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold_i,
  input  logic                    sel_a_n_i,
  input  logic                    sel_b_i,
  input  logic                    sel_c_n_i,
  input  logic                    adv_i,
  input  logic                    rd_nwr_i,
  input  logic [LANES-1:0]        lane_wr_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    burst_lin_i,
  input  logic                    out_en_n_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);

  logic              adv_en;
  zt_op_e            cmd_op;
  logic [ADDR_W-1:0] cmd_addr, rd_addr, wr_addr;
  logic [LANES-1:0]  cmd_lanes, wr_lanes;
  logic              last_idle, rd_valid, wr_valid, head_busy;

  assign adv_en = !hold_i;

  zt_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .adv_en(adv_en),
    .sel_a_n_i(sel_a_n_i), .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i),
    .adv_i(adv_i), .rd_nwr_i(rd_nwr_i), .burst_lin_i(burst_lin_i),
    .lane_wr_n_i(lane_wr_n_i), .addr_i(addr_i),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lanes(cmd_lanes),
    .last_idle(last_idle)
  );

  zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst(rst), .adv_en(adv_en),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lanes(cmd_lanes),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
    .head_busy(head_busy)
  );

  zt_data_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_data (
    .clk(clk), .rst(rst), .adv_en(adv_en),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
    .dq_i(dq_i), .out_en_n_i(out_en_n_i),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          hold_i,
  input logic          adv_i,
  input logic          out_en_n_i,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe,
  input logic          rd_valid,
  input logic          wr_valid,
  input logic          head_busy,
  input logic          last_idle
);

  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !hold_i) |=> (dq_oe || out_en_n_i)); // R1

  AST_OE_GATED: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !out_en_n_i); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(dq_o)); // R7

  AST_WR_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !dq_oe); // R8

  AST_CONT_AFTER_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && adv_i && last_idle) |=> !head_busy); // R9

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> !dq_oe); // R13

endmodule

bind zt_sram_pipe zt_sram_chk #(.DW(LANES*LANE_W)) chk_i (
  .clk(clk), .rst(rst), .hold_i(hold_i), .adv_i(adv_i),
  .out_en_n_i(out_en_n_i), .dq_o(dq_o), .dq_oe(dq_oe),
  .rd_valid(rd_valid), .wr_valid(wr_valid),
  .head_busy(head_busy), .last_idle(last_idle)
);

// File: tb/zt_sram_pipe_tb_top.sv
module zt_sram_pipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int LANES = 4;
  localparam int LW    = 8;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;
  localparam int M_IDLE = 0, M_RD = 1, M_WR = 2;

  logic             clk = 1'b0;
  logic             rst, hold_i, sel_a_n_i, sel_b_i, sel_c_n_i, adv_i, rd_nwr_i;
  logic [LANES-1:0] lane_wr_n_i;
  logic [AW-1:0]    addr_i;
  logic             burst_lin_i, out_en_n_i;
  logic [DW-1:0]    dq_i, dq_o;
  logic             dq_oe;

  zt_sram_pipe #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW), .PIPE_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .hold_i(hold_i),
    .sel_a_n_i(sel_a_n_i), .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i),
    .adv_i(adv_i), .rd_nwr_i(rd_nwr_i), .lane_wr_n_i(lane_wr_n_i),
    .addr_i(addr_i), .burst_lin_i(burst_lin_i), .out_en_n_i(out_en_n_i),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [DW-1:0]    ref_mem [DEPTH];
  int               p1_op, p2_op, m_last, m_step;
  logic [AW-1:0]    p1_adr, p2_adr, m_base;
  logic [LANES-1:0] p1_ln, p2_ln;
  logic             m_drive;
  logic [DW-1:0]    m_dout;
  int               vec_n = 0, bad_n = 0;
  string            tag = "R13";

  function automatic logic [31:0] rnd();
    return $urandom;
  endfunction

  // Address of beat n of a burst, per R10.
  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int n,
                                              input logic lin);
    logic [1:0] lo;
    if (lin) lo = 2'((int'(base[1:0]) + n) % 4);
    else     lo = base[1:0] ^ 2'(n);
    return {base[AW-1:2], lo};
  endfunction

  task automatic model_edge();
    int nop;
    logic [AW-1:0] nadr;
    if (rst) begin
      p1_op = M_IDLE; p2_op = M_IDLE; m_last = M_IDLE; m_step = 0; m_drive = 1'b0;
      m_dout = '0;
    end else if (!hold_i) begin
      if (p2_op == M_WR)
        for (int k = 0; k < LANES; k++)
          if (p2_ln[k]) ref_mem[p2_adr][k*LW +: LW] = dq_i[k*LW +: LW];
      m_drive = (p1_op == M_RD);
      if (p1_op == M_RD) m_dout = ref_mem[p1_adr];
      p2_op = p1_op; p2_adr = p1_adr; p2_ln = p1_ln;
      nop = M_IDLE; nadr = addr_i;
      if (!adv_i) begin
        if (!sel_a_n_i && sel_b_i && !sel_c_n_i) nop = rd_nwr_i ? M_RD : M_WR;
        m_last = nop; m_base = addr_i; m_step = 0;
      end else if (m_last != M_IDLE) begin
        m_step = m_step + 1;
        nop = m_last;
        nadr = beat_addr(m_base, m_step, burst_lin_i);
      end
      p1_op = nop; p1_adr = nadr;
      p1_ln = (nop == M_WR) ? ~lane_wr_n_i : '0;
    end
  endtask

  task automatic check();
    logic exp_oe;
    exp_oe = m_drive && !out_en_n_i;
    vec_n++;
    if (dq_oe !== exp_oe) begin
      bad_n++;
      $display("FAIL %s: dq_oe got %b expected %b at %0t", tag, dq_oe, exp_oe, $time);
    end
    if (exp_oe) begin
      vec_n++;
      if (dq_o !== m_dout) begin
        bad_n++;
        $display("FAIL %s: dq_o got %h expected %h at %0t", tag, dq_o, m_dout, $time);
      end
    end
  endtask

  task automatic tick();
    dq_i = rnd();
    @(posedge clk);
    model_edge();
    #1;
    check();
    @(negedge clk);
    hold_i = 1'b0;
  endtask

  task automatic ld(input logic rd, input logic [AW-1:0] a, input logic [LANES-1:0] wn);
    adv_i = 1'b0; sel_a_n_i = 1'b0; sel_b_i = 1'b1; sel_c_n_i = 1'b0;
    rd_nwr_i = rd; addr_i = a; lane_wr_n_i = wn;
    tick();
  endtask

  // Advance: address, selects and read/write flag are scrambled (R3).
  task automatic cont(input logic [LANES-1:0] wn);
    logic [31:0] r;
    r = rnd();
    adv_i = 1'b1; addr_i = AW'(r); rd_nwr_i = r[8];
    sel_a_n_i = r[9]; sel_b_i = r[10]; sel_c_n_i = r[11]; lane_wr_n_i = wn;
    tick();
  endtask

  task automatic desel();
    adv_i = 1'b0; sel_a_n_i = 1'b0; sel_b_i = 1'b0; sel_c_n_i = 1'b0;
    rd_nwr_i = 1'b1; addr_i = AW'(rnd());
    tick();
  endtask

  task automatic stall();
    hold_i = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad_n++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; hold_i = 1'b0; adv_i = 1'b0; sel_a_n_i = 1'b1; sel_b_i = 1'b0;
    sel_c_n_i = 1'b1; rd_nwr_i = 1'b1; lane_wr_n_i = '1; addr_i = '0;
    burst_lin_i = 1'b0; out_en_n_i = 1'b0; dq_i = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    @(negedge clk);
    tag = "R13 reset";
    tick(); tick();
    rst = 1'b0;

    tag = "R2 R3 fill";
    for (int i = 0; i < DEPTH; i++) ld(1'b0, AW'(i), '0);
    desel(); desel();

    tag = "R12 R11 back-to-back";
    ld(1'b0, 6'd5, '0); ld(1'b1, 6'd5, '1); ld(1'b0, 6'd6, '0); ld(1'b1, 6'd6, '1);
    ld(1'b1, 6'd5, '1); ld(1'b0, 6'd5, 4'b1010); ld(1'b1, 6'd5, '1);
    ld(1'b0, 6'd7, '0); ld(1'b1, 6'd8, '1); ld(1'b0, 6'd9, '0); desel(); desel();

    tag = "R5 lane mask and abort";
    ld(1'b0, 6'd11, 4'b0101); ld(1'b0, 6'd12, 4'b1111); ld(1'b1, 6'd11, '1);
    ld(1'b1, 6'd12, '1); desel(); desel();

    tag = "R6 dummy read";
    out_en_n_i = 1'b1; ld(1'b1, 6'd11, '1); desel(); desel();
    out_en_n_i = 1'b0; ld(1'b1, 6'd11, '1); desel(); desel();

    tag = "R8 write data cycle";
    ld(1'b0, 6'd14, '0); ld(1'b0, 6'd15, '0); ld(1'b1, 6'd14, '1); desel(); desel();

    tag = "R7 hold";
    ld(1'b1, 6'd20, '1); stall(); desel(); stall(); stall(); desel();
    ld(1'b0, 6'd21, '0); stall(); desel(); stall(); desel(); ld(1'b1, 6'd21, '1);
    desel(); desel();

    tag = "R4 deselect";
    ld(1'b1, 6'd22, '1); desel(); ld(1'b0, 6'd23, '0); desel(); desel();
    ld(1'b1, 6'd23, '1); desel(); desel();

    tag = "R9 continue after deselect";
    desel(); cont('0); cont('0); ld(1'b1, 6'd30, '1); cont('1); cont('1); desel(); desel();

    tag = "R10 interleaved burst";
    burst_lin_i = 1'b0;
    ld(1'b1, 6'd34, '1); for (int i = 0; i < 5; i++) cont('1);
    ld(1'b0, 6'd41, '0); for (int i = 0; i < 4; i++) cont(4'b0011);
    ld(1'b1, 6'd41, '1); for (int i = 0; i < 4; i++) cont('1);
    tag = "R10 linear burst";
    burst_lin_i = 1'b1;
    ld(1'b1, 6'd34, '1); for (int i = 0; i < 5; i++) cont('1);
    ld(1'b0, 6'd47, '0); for (int i = 0; i < 3; i++) cont('0);
    ld(1'b1, 6'd45, '1); for (int i = 0; i < 4; i++) cont('1);
    desel(); desel();

    tag = "R3 R11 random mix";
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = rnd();
      if (c % 250 == 0) burst_lin_i = r[31];
      out_en_n_i  = (r[2:0] == 3'd0);
      hold_i      = (r[6:3] == 4'd0);
      adv_i       = (r[8:7] == 2'd0);
      sel_a_n_i   = (r[12:9] == 4'd1);
      sel_b_i     = (r[12:9] != 4'd2);
      sel_c_n_i   = (r[12:9] == 4'd3);
      rd_nwr_i    = r[13];
      lane_wr_n_i = (r[16:14] == 3'd0) ? '1 : LANES'(r[20:17]);
      addr_i      = AW'(r[30:21]);
      tick();
    end
    out_en_n_i = 1'b0;
    desel(); desel();

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

endmodule